// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Sequencer

This block lets a processor core read and write external static RAM over a narrow multiplexed bus. The low address byte and the data byte share one set of lines. The high address byte has its own dedicated outputs. An address-latch strobe tells an external latch when the low address byte on the shared lines can be captured. Active-low read and write strobes then frame the data phase. All strobe timing is counted in cycles of the internal clock. No clock goes out to the memory.

The core issues a request through a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The requester holds the request stable until that edge. The response side has no back-pressure: `rsp_valid` pulses for one cycle and `rsp_rdata` holds the last read byte until the next read completes. The address space is split into a lower and an upper sector at a programmable boundary. Each sector has its own 2-bit wait code, so two memories with different speeds can share the bus. An optional keeper keeps the shared lines at their last driven value while nothing drives them.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset `req_ready`=1, `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_ad_oe`=0, `rsp_valid`=0. `req_ready` is 1 exactly in the cycles in which no access is in progress, including the cycle of the done pulse.
- R2: In the cycle after a request is accepted, `bus_ale`=1, `bus_ad_oe`=1, `bus_ad_o` holds the low address byte and `bus_ahi` holds the high address byte. `bus_ahi` keeps that value until the next request is accepted.
- R3: The strobe (`bus_rd_n` or `bus_wr_n` low) starts the cycle after the address-latch cycle. It lasts 2 cycles plus 0, 1, 2 or 2 extra cycles for wait codes 00, 01, 10 and 11.
- R4: With wait code 11, one extra cycle follows the strobe in which both strobes are high and `bus_ahi` is unchanged, before completion.
- R5: A request whose upper 4 address bits (bits 15:12) are greater than or equal to `cfg_bound` uses `cfg_ws_hi`; otherwise it uses `cfg_ws_lo`. The code is chosen at acceptance, so later configuration changes do not affect an access in progress.
- R6: During a write, `bus_wr_n` is low only while `bus_ad_oe`=1 and `bus_ad_o` equals the write data. `bus_rd_n` stays high.
- R7: During a read, `bus_ad_oe`=0 for the whole strobe. `rsp_rdata` takes the value of `bus_ad_i` at the last clock edge before `bus_rd_n` returns high.
- R8: `rsp_valid` is high for exactly one cycle: the first cycle after the last strobe or hold cycle. `bus_ale` is never high outside the first cycle of an access.
- R9: Whenever `bus_ad_oe`=0, `bus_ad_o` shows the last value driven on the shared lines, or 0 if nothing has been driven since reset. `bus_keep` equals `cfg_keep_en` AND NOT `bus_ad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | sequencer idle, request can be taken |
| req_addr | input | 16 | request address |
| req_wdata | input | 8 | write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | one-cycle completion pulse |
| rsp_rdata | output | 8 | last read byte |
| cfg_bound | input | 4 | sector boundary, compared to address bits 15:12 |
| cfg_ws_lo | input | 2 | wait code, lower sector |
| cfg_ws_hi | input | 2 | wait code, upper sector |
| cfg_keep_en | input | 1 | bus keeper enable |
| bus_ahi | output | 8 | high address byte |
| bus_ad_o | output | 8 | shared address/data lines, outgoing value |
| bus_ad_oe | output | 1 | shared lines driven |
| bus_ad_i | input | 8 | shared lines, incoming value |
| bus_keep | output | 1 | keeper holds the shared lines |
| bus_ale | output | 1 | address-latch strobe |
| bus_rd_n | output | 1 | read strobe, active low |
| bus_wr_n | output | 1 | write strobe, active low |

## Verification
Reads and writes go through every wait code and through addresses on both sides of the sector boundary, including the boundary itself and a boundary of zero. Together these show strobe length, hold-cycle insertion and sector choice. The incoming data changes on every cycle, so a read that samples one edge early or late gives a wrong byte. Requests are also held back-to-back with `req_valid` kept high, which shows acceptance in the done cycle. A wait code is changed in the middle of an access, which shows that the code is latched at acceptance. The idle bus is observed with the keeper both on and off.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_STRB, PH_HOLD} xbus_phase_e;

  // extra strobe cycles for a wait code
  function automatic logic [1:0] extra_strobes(input logic [1:0] code);
    return (code == 2'b00) ? 2'd0 : (code == 2'b01) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/xbus_sector_sel.sv
module xbus_sector_sel #(
  parameter int ADDR_W = 16,
  parameter int BND_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BND_W-1:0]  bound,
  input  logic [1:0]        ws_lo,
  input  logic [1:0]        ws_hi,
  output logic [1:0]        ws
);
  localparam int TOP = ADDR_W - 1;
  logic upper;
  assign upper = (addr[TOP -: BND_W] >= bound);
  assign ws    = upper ? ws_hi : ws_lo;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [1:0]        ws_sel,
  input  logic [DATA_W-1:0] bus_ad_i,
  output xbus_phase_e       phase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata,
  output logic              op_write,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int CNT_W = 2;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       ws_q;

  assign req_ready = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      ws_q      <= '0;
      op_addr   <= '0;
      op_wdata  <= '0;
      op_write  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          op_addr  <= req_addr;
          op_wdata <= req_wdata;
          op_write <= req_write;
          ws_q     <= ws_sel;
          phase    <= PH_ADDR;
        end
        PH_ADDR: begin
          cnt   <= extra_strobes(ws_q) + 2'd1;
          phase <= PH_STRB;
        end
        PH_STRB: if (cnt == '0) begin
          if (!op_write) rsp_rdata <= bus_ad_i;
          if (ws_q == 2'b11) phase <= PH_HOLD;
          else begin
            phase     <= PH_IDLE;
            rsp_valid <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          phase     <= PH_IDLE;
          rsp_valid <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_hold_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> (ws_q == 2'b11));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  xbus_phase_e              phase,
  input  logic [ADDR_W-1:0]        op_addr,
  input  logic [DATA_W-1:0]        op_wdata,
  input  logic                     op_write,
  input  logic                     keep_en,
  output logic [ADDR_W-DATA_W-1:0] bus_ahi,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe,
  output logic                     bus_keep,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n
);
  logic [DATA_W-1:0] keep_q, drv;
  logic              strobe;

  assign strobe    = (phase == PH_STRB);
  assign bus_ale   = (phase == PH_ADDR);
  assign bus_ahi   = op_addr[ADDR_W-1:DATA_W];
  assign bus_rd_n  = !(strobe && !op_write);
  assign bus_wr_n  = !(strobe && op_write);
  assign bus_ad_oe = bus_ale || (strobe && op_write);
  assign drv       = bus_ale ? op_addr[DATA_W-1:0] : op_wdata;
  assign bus_ad_o  = bus_ad_oe ? drv : keep_q;
  assign bus_keep  = keep_en && !bus_ad_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= '0;
    else if (bus_ad_oe) keep_q <= drv;
  end

  assert_ale_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);
  assert_wr_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> (bus_ad_oe && bus_ad_o == op_wdata && bus_rd_n));
  assert_rd_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);
  assert_keep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ad_oe && $past(!bus_ad_oe)) |-> $stable(bus_ad_o));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BND_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_write,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  input  logic [BND_W-1:0]         cfg_bound,
  input  logic [1:0]               cfg_ws_lo,
  input  logic [1:0]               cfg_ws_hi,
  input  logic                     cfg_keep_en,
  output logic [ADDR_W-DATA_W-1:0] bus_ahi,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic                     bus_keep,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n
);
  logic [1:0]        ws_sel;
  xbus_phase_e       phase;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic              op_write;

  xbus_sector_sel #(.ADDR_W(ADDR_W), .BND_W(BND_W)) u_sel (
    .addr(req_addr), .bound(cfg_bound), .ws_lo(cfg_ws_lo), .ws_hi(cfg_ws_hi),
    .ws(ws_sel));

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .ws_sel(ws_sel), .bus_ad_i(bus_ad_i), .phase(phase), .op_addr(op_addr),
    .op_wdata(op_wdata), .op_write(op_write), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata));

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .op_addr(op_addr),
    .op_wdata(op_wdata), .op_write(op_write), .keep_en(cfg_keep_en),
    .bus_ahi(bus_ahi), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
    .bus_keep(bus_keep), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n));
endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, cfg_keep_en = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_ad_i = '0;
  logic [3:0]  cfg_bound = 4'd8;
  logic [1:0]  cfg_ws_lo = 2'd0, cfg_ws_hi = 2'd1;
  logic req_ready, rsp_valid, bus_ad_oe, bus_keep, bus_ale, bus_rd_n, bus_wr_n;
  logic [7:0] rsp_rdata, bus_ahi, bus_ad_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  xbus_ctrl u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit busy = 0, m_wr = 0, m_done = 0;
  int k = 0, S = 0, H = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wd = '0, m_rdata = '0, m_keep = '0;

  function automatic int ext(input logic [1:0] c);
    return (c == 2'd0) ? 0 : (c == 2'd1) ? 1 : 2;
  endfunction
  function automatic bit e_ale();  return busy && k == 1; endfunction
  function automatic bit e_strb(); return busy && k >= 2 && k <= 1 + S; endfunction
  function automatic bit e_oe();   return e_ale() || (e_strb() && m_wr); endfunction
  function automatic logic [7:0] e_ad();
    if (e_ale()) return m_addr[7:0];
    if (e_strb() && m_wr) return m_wd;
    return m_keep;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      busy = 0; k = 0; S = 0; H = 0; m_done = 0; m_wr = 0;
      m_addr = '0; m_wd = '0; m_rdata = '0; m_keep = '0;
    end else begin
      logic [1:0] code;
      if (e_oe()) m_keep = e_ad();
      m_done = 0;
      if (busy) begin
        if (k == 1 + S && !m_wr) m_rdata = bus_ad_i;
        if (k == 1 + S + H) begin busy = 0; m_done = 1; end
        else k++;
      end else if (req_valid) begin
        code = (req_addr[15:12] >= cfg_bound) ? cfg_ws_hi : cfg_ws_lo;
        m_addr = req_addr; m_wd = req_wdata; m_wr = req_write;
        S = 2 + ext(code); H = (code == 2'd3) ? 1 : 0;
        busy = 1; k = 1;
      end
    end
  end

  // lockstep comparison, a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    chk(req_ready == !busy, "R1", "req_ready", req_ready, !busy);
    chk(bus_ale == e_ale(), "R2", "bus_ale", bus_ale, e_ale());
    chk(bus_ahi == m_addr[15:8], "R2", "bus_ahi", bus_ahi, m_addr[15:8]);
    chk(bus_wr_n == !(e_strb() && m_wr), "R6", "bus_wr_n", bus_wr_n, !(e_strb() && m_wr));
    chk(bus_rd_n == !(e_strb() && !m_wr), "R7", "bus_rd_n", bus_rd_n, !(e_strb() && !m_wr));
    chk(bus_ad_oe == e_oe(), "R6", "bus_ad_oe", bus_ad_oe, e_oe());
    chk(bus_ad_o == e_ad(), "R9", "bus_ad_o", bus_ad_o, e_ad());
    chk(bus_keep == (cfg_keep_en && !e_oe()), "R9", "bus_keep", bus_keep, cfg_keep_en && !e_oe());
    chk(rsp_valid == m_done, "R8", "rsp_valid", rsp_valid, m_done);
    chk(rsp_rdata == m_rdata, "R7", "rsp_rdata", rsp_rdata, m_rdata);
  end

  // incoming data changes every cycle so sampling time matters
  always @(negedge clk) bus_ad_i <= 8'(cyc * 37 + 5);

  task automatic access(input logic [15:0] a, input bit w, input logic [7:0] d,
                        input int exp_s, input int exp_h, input string rq);
    int ns, tot;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_write = w; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ns = 0; tot = 0;
    while (!rsp_valid && tot < 50) begin
      if (!bus_rd_n || !bus_wr_n) ns++;
      tot++;
      @(negedge clk);
    end
    chk(ns == exp_s, rq, "strobe cycles", ns, exp_s);
    chk(tot == 1 + exp_s + exp_h, rq, "cycles to done", tot, 1 + exp_s + exp_h);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_valid,
        "R1", "reset outputs", 0, 1);
    rst_n = 1'b1;
    access(16'h1234, 1, 8'hA5, 2, 0, "R3");      // lower sector, code 00
    chk(bus_ad_o == 8'hA5 && bus_keep, "R9", "keeper after write", bus_ad_o, 8'hA5);
    access(16'h3456, 0, 8'h00, 2, 0, "R7");
    access(16'h9ABC, 0, 8'h00, 3, 0, "R5");      // upper sector, code 01
    access(16'h8000, 1, 8'h3C, 3, 0, "R5");      // exactly at boundary -> upper
    access(16'h7FFF, 1, 8'hC3, 2, 0, "R5");      // just below -> lower
    cfg_ws_lo = 2'd2;
    access(16'h0011, 0, 8'h00, 4, 0, "R3");
    access(16'h0022, 1, 8'h5A, 4, 0, "R3");
    cfg_ws_hi = 2'd3;
    access(16'hF0F0, 0, 8'h00, 4, 1, "R4");
    access(16'hE00E, 1, 8'h77, 4, 1, "R4");
    cfg_bound = 4'd0;                              // everything upper
    access(16'h0001, 0, 8'h00, 4, 1, "R5");
    cfg_bound = 4'd8; cfg_ws_lo = 2'd0;
    fork
      access(16'h0101, 0, 8'h00, 2, 0, "R5");    // code latched at accept
      begin repeat (2) @(negedge clk); cfg_ws_lo = 2'd3; end
    join
    cfg_ws_lo = 2'd0;
    cfg_keep_en = 1'b0;
    access(16'h0202, 1, 8'h99, 2, 0, "R9");
    chk(!bus_keep, "R9", "keeper disabled", bus_keep, 0);
    cfg_keep_en = 1'b1;
    // back-to-back with valid held high (R1, R8)
    @(negedge clk);
    req_addr = 16'h4444; req_write = 1'b1; req_wdata = 8'h11; req_valid = 1'b1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule